// File: doc/BRIEF.md
# Interrupt controller command-word sequencer

This block is the byte-wide programming front end of one bank of a programmable interrupt controller. Software reaches it through two 8-bit ports: a command port and a data port. Each port has its own write strobe, read strobe, write data and read data. After reset the block waits for an initialization byte on the command port. It then collects a vector base byte, an optional cascade byte and an optional mode byte on the data port. Flag bits in the first byte decide which of the optional steps are taken. Once the sequence is complete the block is ready: data-port writes load the interrupt mask, and command-port writes carry runtime commands.

Runtime commands come in two kinds. One kind retires in-service bits through end-of-interrupt commands. The other kind selects which status vector a command-port read returns. The priority logic, which lives outside this block, supplies the request and in-service vectors. In return the block sends it one-cycle in-service clear strobes, together with the stored mask and configuration bytes. A command that cannot be accepted has no effect and sets a sticky error flag.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the block is waiting for an initialization byte. `cfg_ready` and `cfg_err` are 0, and the mask and all configuration bytes read 0. The read-select byte is 0x02, so a command-port read returns `irr_in`.
- R2: A command-port write with bit 4 set is an initialization byte, whatever the current state. It is stored in `init_cfg`, it clears `cfg_err`, and the next data-port write is taken as the vector base.
- R3: In the vector step, a data-port write stores `vec_base`. Bit 1 of the initialization byte means single mode. If bit 1 is 0, the next step is the cascade step. Otherwise, if bit 0 (mode byte wanted) is 1, the next step is the mode step. Otherwise the block becomes ready.
- R4: In the cascade step, a data-port write stores `casc_cfg`. The block then moves to the mode step if bit 0 of the initialization byte is 1, and becomes ready otherwise.
- R5: In the mode step, a data-port write stores `mode_cfg` and the block becomes ready.
- R6: When the block is ready, a data-port write loads `irq_mask`. A data-port read returns the mask on `dat_rdata` one clock after the read strobe, and the value holds until the next read.
- R7: An end-of-interrupt command is a ready-state command-port write with bits 4:3 = 00. When bit 5 = 1, bit 7 = 0 and bit 6 = 1, `isr_clr` pulses for one clock, one clock after the write. The pulse is one-hot at the level given by bits 2:0.
- R8: An end-of-interrupt command with bit 5 = 1, bit 7 = 0 and bit 6 = 0 pulses `isr_clr` for the lowest-numbered bit set in `isr_in`. If no bit of `isr_in` is set, no bit pulses.
- R9: A ready-state command-port write with bits 4:3 = 01 is stored as the read select. Bits 1:0 = 10 make command-port reads return `irr_in`, and 11 makes them return `isr_in`. Any other value makes them return 0. As with the data port, the result appears one clock after the read strobe.
- R10: Some command-port writes are rejected. These are any write without bit 4 made outside the ready state, and an end-of-interrupt command with bit 5 = 0 or bit 7 = 1. A rejected write produces no `isr_clr` pulse and leaves the read select unchanged. It sets `cfg_err`, which stays set until the next initialization byte.
- R11: When both ports are written in the same clock, the command-port write is acted on and the data-port write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command-port write strobe |
| cmd_rd | input | 1 | Command-port read strobe |
| cmd_wdata | input | 8 | Command-port write data |
| cmd_rdata | output | 8 | Command-port read data (registered) |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| dat_wdata | input | 8 | Data-port write data |
| dat_rdata | output | 8 | Data-port read data (registered) |
| irr_in | input | 8 | Request vector from the priority logic |
| isr_in | input | 8 | In-service vector from the priority logic |
| isr_clr | output | 8 | One-cycle in-service clear strobes |
| irq_mask | output | 8 | Interrupt mask register |
| vec_base | output | 8 | Stored vector base byte |
| casc_cfg | output | 8 | Stored cascade byte |
| mode_cfg | output | 8 | Stored mode byte |
| init_cfg | output | 8 | Stored initialization byte |
| cfg_ready | output | 1 | Initialization sequence complete |
| cfg_err | output | 1 | Sticky rejected-command flag |

## Verification
The sequencer is driven with all four combinations of the single-mode and mode-wanted flags. Where each following data byte lands (cascade, mode or mask) shows which steps were skipped. An initialization byte is also sent in the middle of a sequence, to show that the sequence restarts. End-of-interrupt commands are walked through a table of specific, non-specific and malformed codes, against in-service vectors with zero, one or several bits set. This separates level decoding, lowest-bit search and rejection. Read-select codes and simultaneous writes on both ports close the set.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int LVL_W  = $clog2(BYTE_W);
  localparam int B_INIT = 4;
  localparam int B_KIND = 3;
  localparam int B_EOI  = 5;
  localparam int B_SPEC = 6;
  localparam int B_ROT  = 7;
  localparam int B_SNGL = 1;
  localparam int B_MODE = 0;

  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t SEL_RESET = byte_t'(2);

  typedef enum logic [2:0] {
    ST_WAIT_INIT, ST_WAIT_VEC, ST_WAIT_CASC, ST_WAIT_MODE, ST_READY
  } seq_st_e;

  function automatic logic is_init(byte_t b);
    return b[B_INIT];
  endfunction

  function automatic logic is_eoi(byte_t b);
    return !b[B_INIT] && !b[B_KIND];
  endfunction

  function automatic logic is_sel(byte_t b);
    return !b[B_INIT] && b[B_KIND];
  endfunction

  function automatic logic eoi_ok(byte_t b);
    return b[B_EOI] && !b[B_ROT];
  endfunction

  function automatic byte_t lowest_one(byte_t v);
    byte_t r = '0;
    for (int i = BYTE_W - 1; i >= 0; i--)
      if (v[i]) r = byte_t'(1) << i;
    return r;
  endfunction

  function automatic byte_t eoi_clear(byte_t b, byte_t isr);
    return b[B_SPEC] ? (byte_t'(1) << b[LVL_W-1:0]) : lowest_one(isr);
  endfunction

  function automatic seq_st_e step_after_vec(byte_t init);
    if (!init[B_SNGL]) return ST_WAIT_CASC;
    if (init[B_MODE])  return ST_WAIT_MODE;
    return ST_READY;
  endfunction

  function automatic seq_st_e step_after_casc(byte_t init);
    return init[B_MODE] ? ST_WAIT_MODE : ST_READY;
  endfunction

  function automatic byte_t read_pick(byte_t sel, byte_t irr, byte_t isr);
    case (sel[1:0])
      2'b10:   return irr;
      2'b11:   return isr;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    init_wr,
  input  logic    dat_wr,
  input  byte_t   wdata,
  output seq_st_e state,
  output byte_t   init_cfg,
  output byte_t   vec_base,
  output byte_t   casc_cfg,
  output byte_t   mode_cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_WAIT_INIT;
      init_cfg <= '0;
      vec_base <= '0;
      casc_cfg <= '0;
      mode_cfg <= '0;
    end else if (init_wr) begin
      init_cfg <= wdata;
      state    <= ST_WAIT_VEC;
    end else if (dat_wr) begin
      case (state)
        ST_WAIT_VEC: begin
          vec_base <= wdata;
          state    <= step_after_vec(init_cfg);
        end
        ST_WAIT_CASC: begin
          casc_cfg <= wdata;
          state    <= step_after_casc(init_cfg);
        end
        ST_WAIT_MODE: begin
          mode_cfg <= wdata;
          state    <= ST_READY;
        end
        default: ;
      endcase
    end
  end

  // R2
  init_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> state == ST_WAIT_VEC);

  // R5
  mode_to_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_MODE && dat_wr && !init_wr) |=> state == ST_READY);
endmodule

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_wr,
  input  byte_t wdata,
  input  logic  ready,
  input  byte_t isr_in,
  output logic  init_hit,
  output logic  bad_cmd,
  output byte_t isr_clr,
  output byte_t rd_sel
);
  logic eoi_hit, sel_hit, eoi_go;

  assign init_hit = cmd_wr && is_init(wdata);
  assign eoi_hit  = cmd_wr && ready && is_eoi(wdata);
  assign sel_hit  = cmd_wr && ready && is_sel(wdata);
  assign eoi_go   = eoi_hit && eoi_ok(wdata);
  assign bad_cmd  = cmd_wr && !is_init(wdata) &&
                    (!ready || (eoi_hit && !eoi_ok(wdata)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_clr <= '0;
      rd_sel  <= SEL_RESET;
    end else begin
      isr_clr <= eoi_go ? eoi_clear(wdata, isr_in) : '0;
      if (sel_hit) rd_sel <= wdata;
    end
  end

  // R7
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_clr));

  // R8
  clr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_clr != '0 && !cmd_wr) |=> isr_clr == '0);

  // R9
  sel_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_sel) |-> $past(cmd_wr && ready));
endmodule

// File: rtl/pic_read_port.sv
module pic_read_port
  import pic_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_rd,
  input  logic  dat_rd,
  input  byte_t rd_sel,
  input  byte_t irr_in,
  input  byte_t isr_in,
  input  byte_t mask,
  output byte_t cmd_rdata,
  output byte_t dat_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_rdata <= '0;
      dat_rdata <= '0;
    end else begin
      if (cmd_rd) cmd_rdata <= read_pick(rd_sel, irr_in, isr_in);
      if (dat_rd) dat_rdata <= mask;
    end
  end

  // R6
  dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_rd |=> $stable(dat_rdata));
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
  import pic_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic       cmd_rd,
  input  logic [7:0] cmd_wdata,
  output logic [7:0] cmd_rdata,
  input  logic       dat_wr,
  input  logic       dat_rd,
  input  logic [7:0] dat_wdata,
  output logic [7:0] dat_rdata,
  input  logic [7:0] irr_in,
  input  logic [7:0] isr_in,
  output logic [7:0] isr_clr,
  output logic [7:0] irq_mask,
  output logic [7:0] vec_base,
  output logic [7:0] casc_cfg,
  output logic [7:0] mode_cfg,
  output logic [7:0] init_cfg,
  output logic       cfg_ready,
  output logic       cfg_err
);
  seq_st_e state;
  logic    dat_wr_eff, init_hit, bad_cmd;
  byte_t   rd_sel;

  assign dat_wr_eff = dat_wr && !cmd_wr;
  assign cfg_ready  = (state == ST_READY);

  pic_init_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .init_wr(init_hit), .dat_wr(dat_wr_eff),
    .wdata(dat_wr_eff ? dat_wdata : cmd_wdata), .state(state),
    .init_cfg(init_cfg), .vec_base(vec_base), .casc_cfg(casc_cfg),
    .mode_cfg(mode_cfg)
  );

  pic_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(cmd_wdata),
    .ready(cfg_ready), .isr_in(isr_in), .init_hit(init_hit),
    .bad_cmd(bad_cmd), .isr_clr(isr_clr), .rd_sel(rd_sel)
  );

  pic_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .dat_rd(dat_rd),
    .rd_sel(rd_sel), .irr_in(irr_in), .isr_in(isr_in), .mask(irq_mask),
    .cmd_rdata(cmd_rdata), .dat_rdata(dat_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_mask <= '0;
      cfg_err  <= 1'b0;
    end else begin
      if (cfg_ready && dat_wr_eff) irq_mask <= dat_wdata;
      if (init_hit)     cfg_err <= 1'b0;
      else if (bad_cmd) cfg_err <= 1'b1;
    end
  end

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ready && dat_wr && !cmd_wr) |=> irq_mask == $past(dat_wdata));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(cmd_wr));

  // R11
  mask_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> $stable(irq_mask));
endmodule

// File: tb/tb_pic_cmd_seq.sv
module tb_pic_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N_EOI = 8;
  // {command, isr_in, expected isr_clr, expected err}
  localparam logic [31:0] EOI_VEC [N_EOI] = '{
    32'h63_00_08_00, 32'h20_58_08_00, 32'h20_80_80_00, 32'h20_00_00_00,
    32'h67_FF_80_00, 32'h60_01_01_00, 32'hA0_FF_00_01, 32'h40_FF_00_01
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, cmd_rd = 0, dat_wr = 0, dat_rd = 0;
  logic [7:0] cmd_wdata = 0, dat_wdata = 0, irr_in = 0, isr_in = 0;
  logic [7:0] cmd_rdata, dat_rdata, isr_clr, irq_mask, vec_base, casc_cfg, mode_cfg, init_cfg;
  logic cfg_ready, cfg_err;
  int total = 0, bad = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_cmd_seq dut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_cmd(logic [7:0] v);
    @(negedge clk); cmd_wr = 1; cmd_wdata = v;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic wr_dat(logic [7:0] v);
    @(negedge clk); dat_wr = 1; dat_wdata = v;
    @(negedge clk); dat_wr = 0;
  endtask

  task automatic rd_cmd(output logic [7:0] v);
    @(negedge clk); cmd_rd = 1;
    @(negedge clk); cmd_rd = 0; v = cmd_rdata;
  endtask

  task automatic rd_dat(output logic [7:0] v);
    @(negedge clk); dat_rd = 1;
    @(negedge clk); dat_rd = 0; v = dat_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 ready", {7'b0, cfg_ready}, 8'h00);
    chk("R1 err", {7'b0, cfg_err}, 8'h00);
    chk("R1 vec", vec_base, 8'h00);
    irr_in = 8'h5A; isr_in = 8'hC3;
    rd_cmd(rv); chk("R1 default select reads irr", rv, 8'h5A);
    rd_dat(rv); chk("R1 mask zero", rv, 8'h00);
    // R10 command outside ready
    wr_cmd(8'h20);
    chk("R10 no clear outside ready", isr_clr, 8'h00);
    chk("R10 err set", {7'b0, cfg_err}, 8'h01);
    // R2/R3/R4/R5 full sequence: cascade + mode
    wr_cmd(8'h11);
    chk("R2 err cleared", {7'b0, cfg_err}, 8'h00);
    chk("R2 init stored", init_cfg, 8'h11);
    wr_dat(8'h20); chk("R3 vec stored", vec_base, 8'h20);
    chk("R3 not ready yet", {7'b0, cfg_ready}, 8'h00);
    wr_dat(8'h04); chk("R4 cascade stored", casc_cfg, 8'h04);
    chk("R4 to mode step", {7'b0, cfg_ready}, 8'h00);
    wr_dat(8'h01); chk("R5 mode stored", mode_cfg, 8'h01);
    chk("R5 ready", {7'b0, cfg_ready}, 8'h01);
    wr_dat(8'hF0); rd_dat(rv); chk("R6 mask readback", rv, 8'hF0);
    // R3 single, no mode byte: ready right after vector
    wr_cmd(8'h12); wr_dat(8'h70);
    chk("R3 single no-mode ready", {7'b0, cfg_ready}, 8'h01);
    wr_dat(8'h0F);
    chk("R3 cascade skipped", casc_cfg, 8'h04);
    chk("R6 mask load", irq_mask, 8'h0F);
    // R3 single with mode byte
    wr_cmd(8'h13); wr_dat(8'h08); wr_dat(8'h1D);
    chk("R3 mode step after vector", mode_cfg, 8'h1D);
    chk("R3 ready after mode", {7'b0, cfg_ready}, 8'h01);
    // R2 restart mid-sequence, R4 cascade without mode
    wr_cmd(8'h11); wr_cmd(8'h10); wr_dat(8'h55);
    chk("R2 restart vec", vec_base, 8'h55);
    wr_dat(8'h99);
    chk("R4 cascade stored", casc_cfg, 8'h99);
    chk("R4 ready without mode", {7'b0, cfg_ready}, 8'h01);
    chk("R4 mode untouched", mode_cfg, 8'h1D);
    // R9 read select
    wr_cmd(8'h0B); rd_cmd(rv); chk("R9 select isr", rv, 8'hC3);
    wr_cmd(8'h08); rd_cmd(rv); chk("R9 select 00 zero", rv, 8'h00);
    wr_cmd(8'h09); rd_cmd(rv); chk("R9 select 01 zero", rv, 8'h00);
    wr_cmd(8'h0A); rd_cmd(rv); chk("R9 select irr", rv, 8'h5A);
    // R11 simultaneous writes
    @(negedge clk); cmd_wr = 1; cmd_wdata = 8'h0A; dat_wr = 1; dat_wdata = 8'h33;
    @(negedge clk); cmd_wr = 0; dat_wr = 0;
    chk("R11 data write dropped", irq_mask, 8'h0F);
    // R7/R8/R10 end-of-interrupt table
    for (int i = 0; i < N_EOI; i++) begin
      isr_in = EOI_VEC[i][23:16];
      wr_cmd(EOI_VEC[i][31:24]);
      chk($sformatf("R7/R8/R10 eoi row %0d clear", i), isr_clr, EOI_VEC[i][15:8]);
      chk($sformatf("R10 eoi row %0d err", i), {7'b0, cfg_err}, EOI_VEC[i][7:0]);
    end
    @(negedge clk);
    chk("R7 pulse one cycle", isr_clr, 8'h00);
    isr_in = 8'hC3;
    rd_cmd(rv); chk("R10 select unchanged", rv, 8'h5A);
    wr_cmd(8'h10);
    chk("R2 err cleared by init", {7'b0, cfg_err}, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule